// File: doc/BRIEF.md
# Victim Store Sequencer

This block sequences the write-back of a dirty cache victim, or of an IO store, to main memory. A small microcode ROM holds one program for IO stores and one for victims. Each step of the program drives the control strobes that the datapath around the block needs: the data shifter enable, the ECC generator enable, a wait request towards the map stage, the finish-task controls and the output-select strobe. The block also reports when it is free to accept new work.

The ROM is addressed by a victim flag and a 4-bit state, so each program has its own row of 16 words. The A stage starts the sequencer while it is free. The sequencer then steps once per cycle until the ROM marks a word as free. It stalls while a hold is asserted or while the memory stage reports that it is busy. A small tracker registers that busy condition from the memory stage. The victim flag can still be raised part way through a sequence, and that moves the sequencer onto the victim program.

All control outputs are registered. They show the word at the state the sequencer has just entered, and they keep their value through any stall.

Top module: `vstore_seq`

## Requirements
- R1: After reset the block is free (`free_o`=1) with `state_o`=0, `victim_o`=0, `mem_wait_o`=0 and every other control output at 0.
- R2: On each step the control outputs load the ROM word at address victim*16+state of the new victim flag and the new state. The ROM word is 9 bits wide. Bit 8 is shift enable, bit 7 is ECC enable, bit 6 is map wait and bit 5 is next-free, and these four are stored active low. Bit 3 is finish-stop, bit 2 is finish-next and bit 1 is make-output, and these three are stored active high. The outputs are the active-high forms. Every word that is free has all other controls at 0.
- R3: `start_o` = `free_o` AND (`io_store_a` OR (`victim_a` AND `map_wait_data`)), combinationally.
- R4: On a step the state becomes 0 if the step is a start, and otherwise it becomes the old state + 1. When the sequencer was busy before the step, bit 0 of the new state is forced to 1.
- R5: `free_o` takes the next-free field of the word loaded in R2. The block steps when it starts, or when it is busy with `hold`=0 and `mem_wait_o`=0.
- R6: The victim flag is updated every cycle. On a start it takes `victim_a` AND `map_wait_data` AND NOT `io_store_a`. While the block is free and not starting, the flag is cleared. While the block is busy, `victim_a`=1 sets the flag. In all other cases it holds.
- R7: `mem_wait_o` loads (NOT `mem_write`) AND (NOT `mem_rom_b6`) on each cycle with `mem_active`=1, and holds otherwise.
- R8: While the block is busy with `hold`=1 or `mem_wait_o`=1, and while it is free with no start, the state and all control outputs hold.
- R9: The IO store program visits states 0,1,3,5,7 and is free at 7. In state 0 only map wait is set. In states 1 and 3 shift and ECC are set, and state 3 also sets finish-next. State 5 sets make-output and finish-stop. The victim program visits 0,1,3,5,7,9 and is free at 9. Its state 0 sets map wait. States 1, 3 and 5 set shift and ECC, and state 5 also sets finish-next. State 7 sets make-output and finish-stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_store_a | input | 1 | IO store present in the A stage |
| victim_a | input | 1 | Dirty victim present in the A stage |
| map_wait_data | input | 1 | Map stage is waiting on data |
| hold | input | 1 | Global hold, stalls a busy sequence |
| mem_active | input | 1 | Memory stage is not idle; enables the wait tracker |
| mem_write | input | 1 | Current memory reference is a write |
| mem_rom_b6 | input | 1 | Memory ROM bit 6 of the current memory word |
| start_o | output | 1 | Start condition this cycle |
| state_o | output | 4 | Sequencer state |
| victim_o | output | 1 | Victim flag (ROM row select) |
| free_o | output | 1 | Sequencer free |
| shift_en_o | output | 1 | Data shifter enable |
| ecc_en_o | output | 1 | ECC generator enable |
| map_wait_o | output | 1 | Wait request towards the map stage |
| fin_stop_o | output | 1 | Stop finish-task load |
| fin_next_o | output | 1 | Finish-next |
| make_out_o | output | 1 | Make output from D |
| mem_wait_o | output | 1 | Registered memory-wait condition |

## Verification
The assertions assume that the sequencer leaves reset free and that any start comes only from the A stage signals while the sequencer is free. They also assume that the memory-wait tracker changes only on cycles with `mem_active` set. The stimulus is random and holds all inputs low through reset and synchronous release. After that it drives hold, memory activity and the A-stage requests independently, with hold and memory writes biased so that sequences both stall and finish. Directed runs cover a clean IO store, a clean victim write-back, a victim arriving mid-sequence, and an IO store together with a victim in the same cycle.

// File: rtl/vstore_pkg.sv
package vstore_pkg;

  localparam int WORD_W    = 9;
  localparam int B_SHIFT_N = 8;
  localparam int B_ECC_N   = 7;
  localparam int B_MAPW_N  = 6;
  localparam int B_FREE_N  = 5;
  localparam int B_STOP    = 3;
  localparam int B_FIN     = 2;
  localparam int B_MKOUT   = 1;

  typedef struct packed {
    logic shift_en;
    logic ecc_en;
    logic map_wait;
    logic free;
    logic fin_stop;
    logic fin_next;
    logic make_out;
  } vst_ctl_t;

  localparam vst_ctl_t CTL_IDLE = '{shift_en: 1'b0, ecc_en: 1'b0, map_wait: 1'b0,
                                    free: 1'b1, fin_stop: 1'b0, fin_next: 1'b0,
                                    make_out: 1'b0};

  function automatic logic [WORD_W-1:0] vst_encode(vst_ctl_t c);
    logic [WORD_W-1:0] w;
    w            = '0;
    w[B_SHIFT_N] = ~c.shift_en;
    w[B_ECC_N]   = ~c.ecc_en;
    w[B_MAPW_N]  = ~c.map_wait;
    w[B_FREE_N]  = ~c.free;
    w[B_STOP]    = c.fin_stop;
    w[B_FIN]     = c.fin_next;
    w[B_MKOUT]   = c.make_out;
    return w;
  endfunction

  function automatic vst_ctl_t vst_decode(logic [WORD_W-1:0] w);
    vst_ctl_t c;
    c.shift_en = ~w[B_SHIFT_N];
    c.ecc_en   = ~w[B_ECC_N];
    c.map_wait = ~w[B_MAPW_N];
    c.free     = ~w[B_FREE_N];
    c.fin_stop = w[B_STOP];
    c.fin_next = w[B_FIN];
    c.make_out = w[B_MKOUT];
    return c;
  endfunction

  // Microprogram: row chosen by victim flag, column by state.
  function automatic vst_ctl_t vst_program(bit vic, int st);
    vst_ctl_t c;
    c = CTL_IDLE;
    if (!vic) begin
      case (st)
        0: begin c.free = 1'b0; c.map_wait = 1'b1; end
        1: begin c.free = 1'b0; c.shift_en = 1'b1; c.ecc_en = 1'b1; end
        3: begin c.free = 1'b0; c.shift_en = 1'b1; c.ecc_en = 1'b1; c.fin_next = 1'b1; end
        5: begin c.free = 1'b0; c.make_out = 1'b1; c.fin_stop = 1'b1; end
        default: c = CTL_IDLE;
      endcase
    end else begin
      case (st)
        0: begin c.free = 1'b0; c.map_wait = 1'b1; end
        1, 3: begin c.free = 1'b0; c.shift_en = 1'b1; c.ecc_en = 1'b1; end
        5: begin c.free = 1'b0; c.shift_en = 1'b1; c.ecc_en = 1'b1; c.fin_next = 1'b1; end
        7: begin c.free = 1'b0; c.make_out = 1'b1; c.fin_stop = 1'b1; end
        default: c = CTL_IDLE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/vst_rom.sv
module vst_rom
  import vstore_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input  logic [STATE_W:0]      addr,
  output logic [WORD_W-1:0]     word
);
  localparam int ROW   = 1 << STATE_W;
  localparam int DEPTH = 2 * ROW;

  logic [WORD_W-1:0] rom_mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom_mem[i] = vst_encode(vst_program(i >= ROW, i % ROW));
  end

  assign word = rom_mem[addr];
endmodule

// File: rtl/vst_ctrl.sv
module vst_ctrl #(
  parameter int STATE_W = 4
) (
  input  logic               free_q,
  input  logic               victim_q,
  input  logic [STATE_W-1:0] state_q,
  input  logic               io_store_a,
  input  logic               victim_a,
  input  logic               map_wait_data,
  input  logic               hold,
  input  logic               mem_wait_q,
  output logic               start,
  output logic               step,
  output logic [STATE_W-1:0] state_d,
  output logic               victim_d
);
  localparam logic [STATE_W-1:0] ONE = STATE_W'(1);

  logic victim_req;
  logic busy_go;

  always_comb begin
    victim_req = victim_a & map_wait_data;
    start      = free_q & (io_store_a | victim_req);
    busy_go    = ~free_q & ~hold & ~mem_wait_q;
    step       = start | busy_go;
  end

  always_comb begin
    if (start) begin
      state_d = '0;
    end else begin
      state_d = state_q + ONE;
      if (!free_q) state_d[0] = 1'b1;
    end
  end

  always_comb begin
    if (start)        victim_d = victim_req & ~io_store_a;
    else if (free_q)  victim_d = 1'b0;
    else if (victim_a) victim_d = 1'b1;
    else              victim_d = victim_q;
  end
endmodule

// File: rtl/vst_memwait.sv
module vst_memwait (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_active,
  input  logic mem_write,
  input  logic mem_rom_b6,
  output logic mem_wait_q
);
  logic mem_wait_d;

  always_comb begin
    mem_wait_d = mem_wait_q;
    if (mem_active) mem_wait_d = ~mem_write & ~mem_rom_b6;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_wait_q <= 1'b0;
    else        mem_wait_q <= mem_wait_d;
  end
endmodule

// File: rtl/vstore_seq.sv
module vstore_seq
  import vstore_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_store_a,
  input  logic               victim_a,
  input  logic               map_wait_data,
  input  logic               hold,
  input  logic               mem_active,
  input  logic               mem_write,
  input  logic               mem_rom_b6,
  output logic               start_o,
  output logic [STATE_W-1:0] state_o,
  output logic               victim_o,
  output logic               free_o,
  output logic               shift_en_o,
  output logic               ecc_en_o,
  output logic               map_wait_o,
  output logic               fin_stop_o,
  output logic               fin_next_o,
  output logic               make_out_o,
  output logic               mem_wait_o
);
  localparam int AW = STATE_W + 1;

  logic [1:0]          rst_pipe;
  logic                rst_n_s;
  logic [STATE_W-1:0]  state_q, state_d;
  logic                victim_q, victim_d;
  logic                start, step;
  logic                mem_wait_q;
  logic [AW-1:0]       rom_addr;
  logic [WORD_W-1:0]   rom_word;
  vst_ctl_t            ctl_q, ctl_d;

  // Reset asserts asynchronously, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  vst_ctrl #(.STATE_W(STATE_W)) u_ctrl (
    .free_q        (ctl_q.free),
    .victim_q      (victim_q),
    .state_q       (state_q),
    .io_store_a    (io_store_a),
    .victim_a      (victim_a),
    .map_wait_data (map_wait_data),
    .hold          (hold),
    .mem_wait_q    (mem_wait_q),
    .start         (start),
    .step          (step),
    .state_d       (state_d),
    .victim_d      (victim_d)
  );

  vst_memwait u_memwait (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mem_active (mem_active),
    .mem_write  (mem_write),
    .mem_rom_b6 (mem_rom_b6),
    .mem_wait_q (mem_wait_q)
  );

  assign rom_addr = {victim_d, state_d};

  vst_rom #(.STATE_W(STATE_W)) u_rom (
    .addr (rom_addr),
    .word (rom_word)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (step) ctl_d = vst_decode(rom_word);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= '0;
      ctl_q   <= CTL_IDLE;
    end else if (step) begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) victim_q <= 1'b0;
    else          victim_q <= victim_d;
  end

  assign start_o    = start;
  assign state_o    = state_q;
  assign victim_o   = victim_q;
  assign free_o     = ctl_q.free;
  assign shift_en_o = ctl_q.shift_en;
  assign ecc_en_o   = ctl_q.ecc_en;
  assign map_wait_o = ctl_q.map_wait;
  assign fin_stop_o = ctl_q.fin_stop;
  assign fin_next_o = ctl_q.fin_next;
  assign make_out_o = ctl_q.make_out;
  assign mem_wait_o = mem_wait_q;
endmodule

module vstore_seq_chk #(
  parameter int STATE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hold,
  input logic               mem_active,
  input logic               start_o,
  input logic [STATE_W-1:0] state_o,
  input logic               victim_o,
  input logic               free_o,
  input logic               shift_en_o,
  input logic               ecc_en_o,
  input logic               map_wait_o,
  input logic               fin_stop_o,
  input logic               fin_next_o,
  input logic               make_out_o,
  input logic               mem_wait_o
);
  p_start_when_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> free_o);

  p_start_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (state_o == '0) && !free_o);

  p_busy_step_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_o && !hold && !mem_wait_o) |=> state_o[0]);

  p_victim_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (free_o && !start_o) |=> !victim_o);

  p_memwait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_active |=> $stable(mem_wait_o));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_o && (hold || mem_wait_o)) |=> $stable(state_o) && !free_o);

  p_free_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    free_o |-> !(shift_en_o || ecc_en_o || map_wait_o || fin_stop_o ||
                 fin_next_o || make_out_o));
endmodule

bind vstore_seq vstore_seq_chk #(.STATE_W(STATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .hold       (hold),
  .mem_active (mem_active),
  .start_o    (start_o),
  .state_o    (state_o),
  .victim_o   (victim_o),
  .free_o     (free_o),
  .shift_en_o (shift_en_o),
  .ecc_en_o   (ecc_en_o),
  .map_wait_o (map_wait_o),
  .fin_stop_o (fin_stop_o),
  .fin_next_o (fin_next_o),
  .make_out_o (make_out_o),
  .mem_wait_o (mem_wait_o)
);

// File: tb/vstore_seq_bench.sv
module vstore_seq_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic io_store_a, victim_a, map_wait_data, hold, mem_active, mem_write, mem_rom_b6;
  logic start_o, victim_o, free_o, shift_en_o, ecc_en_o, map_wait_o;
  logic fin_stop_o, fin_next_o, make_out_o, mem_wait_o;
  logic [3:0] state_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // model state
  logic [3:0] m_state;
  logic       m_free, m_vic, m_mw, m_start;
  logic [6:0] m_out;   // {sh, ecc, mapw, free, stop, fin, mk}

  always #5 clk = ~clk;

  vstore_seq u_vstore_seq (
    .clk(clk), .rst_n(rst_n), .io_store_a(io_store_a), .victim_a(victim_a),
    .map_wait_data(map_wait_data), .hold(hold), .mem_active(mem_active),
    .mem_write(mem_write), .mem_rom_b6(mem_rom_b6), .start_o(start_o),
    .state_o(state_o), .victim_o(victim_o), .free_o(free_o),
    .shift_en_o(shift_en_o), .ecc_en_o(ecc_en_o), .map_wait_o(map_wait_o),
    .fin_stop_o(fin_stop_o), .fin_next_o(fin_next_o), .make_out_o(make_out_o),
    .mem_wait_o(mem_wait_o)
  );

  // Expected ROM contents from R9/R2, active-high form.
  function automatic logic [6:0] exp_word(logic vic, logic [3:0] st);
    if (!vic) begin
      case (st)
        4'd0: return 7'b0010000;
        4'd1: return 7'b1100000;
        4'd3: return 7'b1100010;
        4'd5: return 7'b0000101;
        default: return 7'b0001000;
      endcase
    end else begin
      case (st)
        4'd0: return 7'b0010000;
        4'd1, 4'd3: return 7'b1100000;
        4'd5: return 7'b1100010;
        4'd7: return 7'b0000101;
        default: return 7'b0001000;
      endcase
    end
  endfunction

  function automatic logic [6:0] dut_out();
    return {shift_en_o, ecc_en_o, map_wait_o, free_o, fin_stop_o, fin_next_o, make_out_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // One cycle: called at a negedge. Drive, check start, predict, clock, check.
  task automatic cycle(input logic io, input logic va, input logic mwd,
                       input logic hd, input logic ma, input logic mwr, input logic b6);
    logic       step, vn, stall;
    logic [3:0] sn;
    io_store_a = io; victim_a = va; map_wait_data = mwd; hold = hd;
    mem_active = ma; mem_write = mwr; mem_rom_b6 = b6;
    #1;
    m_start = m_free & (io | (va & mwd));
    chk("R3 start", start_o, m_start);
    if (m_start)     vn = va & mwd & ~io;
    else if (m_free) vn = 1'b0;
    else if (va)     vn = 1'b1;
    else             vn = m_vic;
    step  = m_start | (~m_free & ~hd & ~m_mw);
    stall = ~step;
    if (step) begin
      sn = m_start ? 4'd0 : m_state + 4'd1;
      if (!m_free) sn[0] = 1'b1;
      m_state = sn;
      m_out   = exp_word(vn, sn);
      m_free  = m_out[3];
    end
    m_vic = vn;
    if (ma) m_mw = ~mwr & ~b6;
    @(posedge clk);
    @(negedge clk);
    chk(stall ? "R8 state hold" : "R4 state", state_o, m_state);
    chk(stall ? "R8 outputs hold" : "R2 outputs", dut_out(), m_out);
    chk("R5 free", free_o, m_free);
    chk("R6 victim", victim_o, m_vic);
    chk("R7 mem_wait", mem_wait_o, m_mw);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    io_store_a = 0; victim_a = 0; map_wait_data = 0; hold = 0;
    mem_active = 0; mem_write = 0; mem_rom_b6 = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 free", free_o, 1'b1);
    chk("R1 state", state_o, 4'd0);
    chk("R1 victim", victim_o, 1'b0);
    chk("R1 mem_wait", mem_wait_o, 1'b0);
    chk("R1 outputs", dut_out(), 7'b0001000);
    m_state = 0; m_free = 1; m_vic = 0; m_mw = 0; m_out = 7'b0001000;

    // R8 free with no start holds
    cycle(0, 0, 0, 0, 0, 0, 0);
    cycle(0, 1, 0, 0, 0, 0, 0);

    // R9 clean IO store: 5 steps to free at state 7
    cycle(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 0, 0, 0);
    chk("R9 io end state", state_o, 4'd7);
    chk("R9 io free", free_o, 1'b1);

    // R9 clean victim: 6 steps to free at state 9
    cycle(0, 1, 1, 0, 0, 0, 0);
    chk("R9 victim flag", victim_o, 1'b1);
    for (int i = 0; i < 5; i++) cycle(0, 0, 0, 0, 0, 0, 0);
    chk("R9 victim end state", state_o, 4'd9);
    chk("R9 victim free", free_o, 1'b1);
    cycle(0, 0, 0, 0, 0, 0, 0);
    chk("R6 victim cleared when free", victim_o, 1'b0);

    // R6 IO store and victim together: IO row wins
    cycle(1, 1, 1, 0, 0, 0, 0);
    chk("R6 io priority", victim_o, 1'b0);
    // R8 hold stall, then memory-wait stall (R7)
    cycle(0, 0, 0, 1, 0, 0, 0);
    cycle(0, 0, 0, 1, 1, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 1, 0);
    // R6 victim arrives mid-sequence, moves to victim row
    cycle(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, 0, 0, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 6) == 0, ($urandom % 4) == 0, $urandom % 2,
            ($urandom % 5) == 0, $urandom % 2, ($urandom % 3) != 0, $urandom % 2);
    end
    finish_run();
  end
endmodule